// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the state machine that steers a multicycle 32-bit load/store datapath built around a single shared memory and a single ALU. Each instruction passes through a common fetch cycle and a common decode cycle. After decode, the 6-bit opcode held in the instruction register picks one of four short tails: memory access, register-register arithmetic, conditional branch or jump. In every state the block drives the full set of datapath selects and enables, and it merges the unconditional and the zero-qualified PC update requests into one PC load enable.

The controls are a function of the current state alone (Moore outputs). The one exception is the PC load enable, which also looks at the ALU zero flag so that a branch resolves in the same cycle it compares. A load takes five cycles. A store and an arithmetic instruction each take four. A branch and a jump each take three. An opcode the block does not recognise costs two cycles and changes no state. Reset is asserted asynchronously and released through a synchronizer. While reset is held, the sequencer sits in fetch.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While reset is held, and until the synchronized release, the outputs show the fetch encoding.
- R2: Fetch drives mem_rd=1, mem_addr_sel=0, ir_ld=1, alu_a_sel=0, alu_b_sel=01, alu_op=00, pc_src=00, pc_upd=1 and all other controls 0, and it always moves on to decode.
- R3: Decode drives alu_a_sel=0, alu_b_sel=11, alu_op=00 and all other controls 0. It then dispatches on the opcode: 000000 selects arithmetic, 100011 and 101011 select memory access, 000100 selects branch and 000010 selects jump.
- R4: For a load or a store, the address state drives alu_a_sel=1, alu_b_sel=10 and alu_op=00.
- R5: A load next drives mem_rd=1 and mem_addr_sel=1, then rf_we=1, wb_sel=1 and dst_sel=0, then returns to fetch (five cycles in total).
- R6: A store next drives mem_wr=1 and mem_addr_sel=1, then returns to fetch (four cycles in total).
- R7: Arithmetic drives alu_a_sel=1, alu_b_sel=00 and alu_op=10, then dst_sel=1, wb_sel=0 and rf_we=1, then returns to fetch.
- R8: Branch drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_src=01 and pc_upd_cond=1, then returns to fetch. In this state pc_we equals alu_zero.
- R9: Jump drives pc_src=10 and pc_upd=1 in its third cycle, then returns to fetch.
- R10: pc_we is pc_upd OR (pc_upd_cond AND alu_zero). In every state other than branch, alu_zero has no effect on any output.
- R11: An unrecognised opcode in decode leads straight back to fetch, and no memory, register-file or PC write is asserted in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| mem_addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_ld | output | 1 | Instruction register load |
| dst_sel | output | 1 | Destination register field: 0 bits 20:16, 1 bits 15:11 |
| wb_sel | output | 1 | Write-back source: 0 ALU output, 1 memory data register |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 A register |
| alu_b_sel | output | 2 | ALU B operand: 00 B reg, 01 four, 10 sign-extended immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| pc_upd | output | 1 | Unconditional PC update request |
| pc_upd_cond | output | 1 | Zero-qualified PC update request |
| pc_we | output | 1 | Final PC load enable |

## Verification
The sequencer runs back-to-back instruction streams of every recognised opcode, plus an all-ones opcode, and every cycle is compared against an expected control word. The length of each stream separates the five-, four- and three-cycle paths, so a misrouted dispatch shows up as a shifted fetch. Branches are run once with zero high and once with zero low, which separates a taken from a not-taken PC load. Every other cycle holds zero high, so any leak of the flag into the non-branch outputs is visible.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STWR   = 4'd5,
    ST_REXE   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BEQ    = 4'd8,
    ST_JUMP   = 4'd9
  } state_e;

  // ALU B operand select codes
  localparam logic [SEL_W-1:0] BSEL_REG   = 2'b00;
  localparam logic [SEL_W-1:0] BSEL_FOUR  = 2'b01;
  localparam logic [SEL_W-1:0] BSEL_IMM   = 2'b10;
  localparam logic [SEL_W-1:0] BSEL_BROFF = 2'b11;

  // ALU operation class codes
  localparam logic [SEL_W-1:0] AOP_ADD    = 2'b00;
  localparam logic [SEL_W-1:0] AOP_SUB    = 2'b01;
  localparam logic [SEL_W-1:0] AOP_FUNCT  = 2'b10;

  // PC source codes
  localparam logic [SEL_W-1:0] PSRC_ALU   = 2'b00;
  localparam logic [SEL_W-1:0] PSRC_OUT   = 2'b01;
  localparam logic [SEL_W-1:0] PSRC_JMP   = 2'b10;

  typedef struct packed {
    logic             addr_sel;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_ld;
    logic             dst_sel;
    logic             wb_sel;
    logic             rf_we;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] pc_src;
    logic             pc_upd;
    logic             pc_upd_cond;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mcc_rst_sync.sv
module mcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
#(
  parameter int              OPC_W   = 6,
  parameter logic [OPC_W-1:0] OPC_ALU = 6'b000000,
  parameter logic [OPC_W-1:0] OPC_LD  = 6'b100011,
  parameter logic [OPC_W-1:0] OPC_ST  = 6'b101011,
  parameter logic [OPC_W-1:0] OPC_BR  = 6'b000100,
  parameter logic [OPC_W-1:0] OPC_JMP = 6'b000010
) (
  input  state_e           state_q,
  input  logic [OPC_W-1:0] opcode,
  output state_e           state_d
);

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_LD || opcode == OPC_ST) begin
          state_d = ST_ADDR;
        end else if (opcode == OPC_ALU) begin
          state_d = ST_REXE;
        end else if (opcode == OPC_BR) begin
          state_d = ST_BEQ;
        end else if (opcode == OPC_JMP) begin
          state_d = ST_JUMP;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_ADDR:   state_d = (opcode == OPC_LD) ? ST_LDRD : ST_STWR;
      ST_LDRD:   state_d = ST_LDWB;
      ST_REXE:   state_d = ST_RWB;
      default:   state_d = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  state_e state_q,
  output ctrl_t  ctrl
);

  always_comb begin
    ctrl = CTRL_IDLE;
    unique case (state_q)
      ST_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.addr_sel  = 1'b0;
        ctrl.ir_ld     = 1'b1;
        ctrl.alu_a_sel = 1'b0;
        ctrl.alu_b_sel = BSEL_FOUR;
        ctrl.alu_op    = AOP_ADD;
        ctrl.pc_src    = PSRC_ALU;
        ctrl.pc_upd    = 1'b1;
      end
      ST_DECODE: begin
        ctrl.alu_a_sel = 1'b0;
        ctrl.alu_b_sel = BSEL_BROFF;
        ctrl.alu_op    = AOP_ADD;
      end
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSEL_IMM;
        ctrl.alu_op    = AOP_ADD;
      end
      ST_LDRD: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctrl.rf_we   = 1'b1;
        ctrl.wb_sel  = 1'b1;
        ctrl.dst_sel = 1'b0;
      end
      ST_STWR: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_REXE: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSEL_REG;
        ctrl.alu_op    = AOP_FUNCT;
      end
      ST_RWB: begin
        ctrl.dst_sel = 1'b1;
        ctrl.wb_sel  = 1'b0;
        ctrl.rf_we   = 1'b1;
      end
      ST_BEQ: begin
        ctrl.alu_a_sel   = 1'b1;
        ctrl.alu_b_sel   = BSEL_REG;
        ctrl.alu_op      = AOP_SUB;
        ctrl.pc_src      = PSRC_OUT;
        ctrl.pc_upd_cond = 1'b1;
      end
      ST_JUMP: begin
        ctrl.pc_src = PSRC_JMP;
        ctrl.pc_upd = 1'b1;
      end
      default: ctrl = CTRL_IDLE;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int               OPC_W       = 6,
  parameter int               SYNC_STAGES = 2,
  parameter logic [OPC_W-1:0] OPC_ALU     = 6'b000000,
  parameter logic [OPC_W-1:0] OPC_LD      = 6'b100011,
  parameter logic [OPC_W-1:0] OPC_ST      = 6'b101011,
  parameter logic [OPC_W-1:0] OPC_BR      = 6'b000100,
  parameter logic [OPC_W-1:0] OPC_JMP     = 6'b000010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_zero,
  output logic             mem_addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_ld,
  output logic             dst_sel,
  output logic             wb_sel,
  output logic             rf_we,
  output logic             alu_a_sel,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic [SEL_W-1:0] alu_op,
  output logic [SEL_W-1:0] pc_src,
  output logic             pc_upd,
  output logic             pc_upd_cond,
  output logic             pc_we
);

  logic   rst_i_n;
  state_e state_q;
  state_e state_d;
  ctrl_t  ctrl;

  mcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mcc_next_state #(
    .OPC_W   (OPC_W),
    .OPC_ALU (OPC_ALU),
    .OPC_LD  (OPC_LD),
    .OPC_ST  (OPC_ST),
    .OPC_BR  (OPC_BR),
    .OPC_JMP (OPC_JMP)
  ) u_next (
    .state_q (state_q),
    .opcode  (opcode),
    .state_d (state_d)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

  mcc_ctrl_decode u_dec (
    .state_q (state_q),
    .ctrl    (ctrl)
  );

  assign mem_addr_sel = ctrl.addr_sel;
  assign mem_rd       = ctrl.mem_rd;
  assign mem_wr       = ctrl.mem_wr;
  assign ir_ld        = ctrl.ir_ld;
  assign dst_sel      = ctrl.dst_sel;
  assign wb_sel       = ctrl.wb_sel;
  assign rf_we        = ctrl.rf_we;
  assign alu_a_sel    = ctrl.alu_a_sel;
  assign alu_b_sel    = ctrl.alu_b_sel;
  assign alu_op       = ctrl.alu_op;
  assign pc_src       = ctrl.pc_src;
  assign pc_upd       = ctrl.pc_upd;
  assign pc_upd_cond  = ctrl.pc_upd_cond;

  // Final PC load: unconditional request, or conditional request qualified by zero
  assign pc_we = ctrl.pc_upd | (ctrl.pc_upd_cond & alu_zero);

  logic opc_known;
  assign opc_known = (opcode == OPC_ALU) || (opcode == OPC_LD) || (opcode == OPC_ST) ||
                     (opcode == OPC_BR)  || (opcode == OPC_JMP);

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

  a_r11_unknown_back_to_fetch: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_DECODE && !opc_known) |=> ir_ld);

  a_r5_read_then_writeback: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_LDRD) |=> (rf_we && wb_sel));

  a_r6_store_then_fetch: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_wr |=> ir_ld);

  a_r8_branch_zero_gate: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_BEQ) |-> (pc_we == alu_zero));

  a_r8_branch_single_cycle: assert property (@(posedge clk) disable iff (!rst_i_n)
    pc_upd_cond |=> (ir_ld && !pc_upd_cond));

  a_r3_one_storage_access: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({mem_rd, mem_wr, rf_we}));

endmodule

// File: tb/sim_mc_ctrl_fsm.sv
module sim_mc_ctrl_fsm;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [5:0] opcode;
  logic       alu_zero;
  logic       mem_addr_sel, mem_rd, mem_wr, ir_ld, dst_sel, wb_sel, rf_we, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic       pc_upd, pc_upd_cond, pc_we;

  mc_ctrl_fsm u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .mem_addr_sel(mem_addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .rf_we(rf_we), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
    .pc_upd(pc_upd), .pc_upd_cond(pc_upd_cond), .pc_we(pc_we)
  );

  localparam logic [5:0] OP_R   = 6'b000000;
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_SW  = 6'b101011;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_J   = 6'b000010;
  localparam logic [5:0] OP_BAD = 6'b111111;

  typedef struct {
    logic [16:0] v;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string fetch_tag = "R2";

  // Control word: addr_sel mem_rd mem_wr ir_ld dst wb rf_we a_sel b_sel op pc_src upd cond we
  function automatic logic [16:0] mk(input logic iord, mr, mw, irw, rd, m2r, rw, asa,
                                     input logic [1:0] asb, aop, pcs,
                                     input logic pw, pwc, pwe);
    return {iord, mr, mw, irw, rd, m2r, rw, asa, asb, aop, pcs, pw, pwc, pwe};
  endfunction

  function automatic logic [16:0] v_fetch();
    return mk(0,1,0,1,0,0,0,0,2'b01,2'b00,2'b00,1,0,1);
  endfunction

  task automatic step(input logic [5:0] opc, input logic z, input logic [16:0] e, input string tag);
    item_t it;
    @(negedge clk);
    opcode   = opc;
    alu_zero = z;
    it.v   = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Driver: pushes the expected control word for each cycle of one instruction
  task automatic instr(input logic [5:0] opc, input logic z);
    step(opc, 1'b1, v_fetch(), fetch_tag);
    fetch_tag = "R2";
    step(opc, 1'b1, mk(0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00,0,0,0), "R3");
    case (opc)
      OP_LW: begin
        step(opc, 1'b1, mk(0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00,0,0,0), "R4");
        step(opc, 1'b1, mk(1,1,0,0,0,0,0,0,2'b00,2'b00,2'b00,0,0,0), "R5");
        step(opc, 1'b1, mk(0,0,0,0,0,1,1,0,2'b00,2'b00,2'b00,0,0,0), "R5");
      end
      OP_SW: begin
        step(opc, 1'b1, mk(0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00,0,0,0), "R4");
        step(opc, 1'b1, mk(1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00,0,0,0), "R6");
      end
      OP_R: begin
        step(opc, 1'b1, mk(0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00,0,0,0), "R7");
        step(opc, 1'b1, mk(0,0,0,0,1,0,1,0,2'b00,2'b00,2'b00,0,0,0), "R7");
      end
      OP_BEQ: begin
        step(opc, z, mk(0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01,0,1,z), z ? "R8" : "R10");
      end
      OP_J: begin
        step(opc, 1'b1, mk(0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10,1,0,1), "R9");
      end
      default: fetch_tag = "R11";
    endcase
  endtask

  // Monitor: compares outputs against the queue head away from the clock edge
  always begin
    item_t it;
    logic [16:0] act;
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      it  = q.pop_front();
      act = {mem_addr_sel, mem_rd, mem_wr, ir_ld, dst_sel, wb_sel, rf_we, alu_a_sel,
             alu_b_sel, alu_op, pc_src, pc_upd, pc_upd_cond, pc_we};
      checks++;
      if (act !== it.v) begin
        errors++;
        $display("FAIL %s actual %b expected %b at %0t", it.tag, act, it.v, $time);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    opcode   = OP_R;
    alu_zero = 1'b0;
    // R1: fetch encoding held in reset, zero low so pc_we comes from pc_upd only
    repeat (3) step(OP_LW, 1'b0, v_fetch(), "R1");
    step(OP_LW, 1'b0, v_fetch(), "R1");
    rst_n = 1'b1;
    step(OP_LW, 1'b1, v_fetch(), "R1");
    instr(OP_R, 1'b1);
    instr(OP_LW, 1'b1);
    instr(OP_SW, 1'b1);
    instr(OP_BEQ, 1'b1);
    instr(OP_BEQ, 1'b0);
    instr(OP_J, 1'b1);
    instr(OP_BAD, 1'b1);
    instr(OP_R, 1'b1);
    instr(OP_SW, 1'b1);
    instr(OP_LW, 1'b1);
    instr(OP_BEQ, 1'b0);
    instr(OP_J, 1'b1);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule